// File: doc/BRIEF.md
# Condition-Field Predicate Mask Generator

This block turns a bank of 4-bit condition fields into a per-element enable mask for a vector operation. A 3-bit selector picks one flag from each field (less-than, greater-than, equal or summary-overflow). It also picks whether that flag enables the element when set or when clear. Element i takes its enable from the field at a fixed base position plus i. With the default base of 48, the predicate fields stay clear of vector result writes that start lower in the bank, unless the vector length is large.

A request is a single `start` strobe. It comes with the selector, the vector length and a mode bit. In one-pass mode the whole mask is decoded at once and is ready one cycle later. In stepped mode a small state machine has two states, IDLE and WALK. It fills one mask bit per cycle, and a single shared flag picker is reused for every element. The transitions are:
- IDLE→IDLE on a one-pass start, on a start with zero length, or with no start.
- IDLE→WALK on a stepped start with nonzero length.
- WALK→WALK while elements remain.
- WALK→IDLE after the last element.

Vector lengths beyond the available fields raise an error flag, and the mask is clamped.

Top module: `cfpred_mask_gen`

## Requirements
- R1: Field k of the bank occupies bits [4k+3:4k] of `cf_bank`. Within a field, bit 3 is LT, bit 2 is GT, bit 1 is EQ and bit 0 is SO.
- R2: `cond_sel[2:1]` chooses the flag: 00 selects LT, 01 selects GT, 10 selects EQ and 11 selects SO. `cond_sel[0]`=0 enables an element whose flag is set, and 1 enables an element whose flag is clear.
- R3: Mask bit i is taken from field BASE_FIELD+i, which is field 48+i by default.
- R4: Mask bits at positions at or above the effective length are zero. The effective length is min(`vec_len`, 16).
- R5: `vl_err` is loaded at every accepted start with (`vec_len` > 16) and holds until the next accepted start. An oversized length is clamped to 16 elements.
- R6: A start taken in IDLE with `step_mode`=0 produces the final mask and a `done` pulse in the cycle after the sampling edge, and `busy` stays low.
- R7: A start taken in IDLE with `step_mode`=1 and effective length n>0 holds `busy` high for n cycles. It raises `done` at the n-th edge after the start, and `busy` is low while `done` is high.
- R8: A start that arrives while `busy` is high is ignored. The running request finishes with its own selector, length and error flag.
- R9: An effective length of zero completes in the cycle after the start with an all-zero mask and no `busy`, in either mode.
- R10: After reset, `mask`, `done`, `busy` and `vl_err` are all zero.
- R11: `done` lasts one cycle unless another start is accepted in that cycle. `mask` keeps its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted only in IDLE |
| step_mode | input | 1 | 0 = one-pass decode, 1 = one element per cycle |
| cond_sel | input | 3 | Flag choice in bits 2:1, test polarity in bit 0 |
| vec_len | input | VL_W (7) | Requested vector length |
| cf_bank | input | NUM_FIELDS*4 (256) | Flattened condition-field bank, field k at bits [4k+3:4k] |
| mask | output | LANES (16) | Element enable mask |
| done | output | 1 | Request complete, mask valid |
| busy | output | 1 | Stepped walk in progress |
| vl_err | output | 1 | Last accepted length exceeded the field count |

## Verification
The bench sweeps every selector code over vector lengths 0 to 18, in both modes, across all-zero, all-one and scrambled banks. This catches a swapped flag position, an inverted polarity, a base off by one field and a mask that leaks past the length. In stepped runs it counts the `busy` cycles, so a walk that ends one element early or late shows up as a wrong `done` cycle or as a missing last bit. Lengths 16, 17 and 18 probe the clamp, where an unclamped index would read past the bank or leave `vl_err` wrong. A stray start injected mid-walk with a different selector must leave the result untouched, which exposes a machine that restarts or relatches while busy.

// File: rtl/cfpred_pkg.sv
package cfpred_pkg;

    localparam int FIELD_W = 4;

    typedef enum logic [1:0] {
        FLAG_LT = 2'd0,
        FLAG_GT = 2'd1,
        FLAG_EQ = 2'd2,
        FLAG_SO = 2'd3
    } flag_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } state_e;

    // Bit position of a flag inside one field: LT is the top bit.
    function automatic int flag_pos(flag_e f);
        int pos;
        unique case (f)
            FLAG_LT: pos = 3;
            FLAG_GT: pos = 2;
            FLAG_EQ: pos = 1;
            FLAG_SO: pos = 0;
            default: pos = 0;
        endcase
        return pos;
    endfunction

endpackage

// File: rtl/cfpred_bit_pick.sv
module cfpred_bit_pick
    import cfpred_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    input  logic [2:0]         sel,
    output logic               hit
);
    flag_e flag;
    logic  raw;

    always_comb begin
        flag = flag_e'(sel[2:1]);
        raw  = field[flag_pos(flag)];
        hit  = raw ^ sel[0];
    end
endmodule

// File: rtl/cfpred_lane_decode.sv
module cfpred_lane_decode
    import cfpred_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic [LANES*FIELD_W-1:0] win,
    input  logic [2:0]               sel,
    output logic [LANES-1:0]         hit
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        cfpred_bit_pick u_pick (
            .field (win[i*FIELD_W +: FIELD_W]),
            .sel   (sel),
            .hit   (hit[i])
        );
    end
endmodule

// File: rtl/cfpred_vl_limit.sv
module cfpred_vl_limit #(
    parameter int VL_W  = 7,
    parameter int LANES = 16,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic [VL_W-1:0]  vec_len,
    output logic [CNT_W-1:0] eff_vl,
    output logic             over,
    output logic [LANES-1:0] lane_en
);
    always_comb begin
        over   = (vec_len > VL_W'(LANES));
        eff_vl = over ? CNT_W'(LANES) : vec_len[CNT_W-1:0];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_en
        assign lane_en[i] = (CNT_W'(i) < eff_vl);
    end
endmodule

// File: rtl/cfpred_mask_gen.sv
module cfpred_mask_gen
    import cfpred_pkg::*;
#(
    parameter int NUM_FIELDS = 64,
    parameter int BASE_FIELD = 48,
    parameter int VL_W       = 7,
    localparam int LANES     = NUM_FIELDS - BASE_FIELD,
    localparam int BANK_W    = NUM_FIELDS * FIELD_W,
    localparam int CNT_W     = $clog2(LANES + 1),
    localparam int IDX_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step_mode,
    input  logic [2:0]        cond_sel,
    input  logic [VL_W-1:0]   vec_len,
    input  logic [BANK_W-1:0] cf_bank,
    output logic [LANES-1:0]  mask,
    output logic              done,
    output logic              busy,
    output logic              vl_err
);
    state_e                  state, state_nx;
    logic [LANES*FIELD_W-1:0] win;
    logic [LANES-1:0]        bulk_hit;
    logic [LANES-1:0]        lane_en;
    logic [CNT_W-1:0]        eff_vl;
    logic                    over;
    logic [2:0]              sel_q;
    logic [IDX_W-1:0]        walk_idx;
    logic [IDX_W-1:0]        last_q;
    logic [FIELD_W-1:0]      walk_field;
    logic                    walk_bit;
    logic                    accept;
    logic                    go_walk;

    // Predicate window: fields BASE_FIELD .. NUM_FIELDS-1.
    assign win = cf_bank[BASE_FIELD*FIELD_W +: LANES*FIELD_W];

    if (BASE_FIELD > 0) begin : g_low
        logic unused_low;
        assign unused_low = ^cf_bank[BASE_FIELD*FIELD_W-1:0];
    end

    cfpred_vl_limit #(.VL_W(VL_W), .LANES(LANES)) u_limit (
        .vec_len (vec_len),
        .eff_vl  (eff_vl),
        .over    (over),
        .lane_en (lane_en)
    );

    cfpred_lane_decode #(.LANES(LANES)) u_bulk (
        .win (win),
        .sel (cond_sel),
        .hit (bulk_hit)
    );

    assign walk_field = win[walk_idx*FIELD_W +: FIELD_W];

    cfpred_bit_pick u_walk (
        .field (walk_field),
        .sel   (sel_q),
        .hit   (walk_bit)
    );

    assign accept  = start && (state == ST_IDLE);
    assign go_walk = accept && step_mode && (eff_vl != '0);
    assign busy    = (state == ST_WALK);

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (go_walk) state_nx = ST_WALK;
            ST_WALK: if (walk_idx == last_q) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output and datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask     <= '0;
            done     <= 1'b0;
            vl_err   <= 1'b0;
            sel_q    <= '0;
            walk_idx <= '0;
            last_q   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        vl_err   <= over;
                        sel_q    <= cond_sel;
                        walk_idx <= '0;
                        last_q   <= IDX_W'(eff_vl - CNT_W'(1));
                        if (go_walk) begin
                            mask <= '0;
                        end else begin
                            mask <= bulk_hit & lane_en;
                            done <= 1'b1;
                        end
                    end
                end
                ST_WALK: begin
                    mask[walk_idx] <= walk_bit;
                    walk_idx       <= walk_idx + IDX_W'(1);
                    if (walk_idx == last_q) done <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfpred_checker.sv
module cfpred_checker #(
    parameter int LANES = 16,
    parameter int VL_W  = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             step_mode,
    input logic [VL_W-1:0]  vec_len,
    input logic [LANES-1:0] mask,
    input logic             done,
    input logic             busy,
    input logic             vl_err
);
    logic [31:0] cap_vl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_vl <= '0;
        else if (start && !busy) cap_vl <= 32'(vec_len);
    end

    AST_MASK_ABOVE_VL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((32'(mask) >> cap_vl) == 32'd0)); // R4

    AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (vl_err == ($past(vec_len) > VL_W'(LANES)))); // R5

    AST_ONE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !step_mode) |=> (done && !busy)); // R6

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7

    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(vl_err)); // R8

    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && vec_len == '0) |=> (done && mask == '0 && !busy)); // R9

    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start && !busy)) |=> $stable(mask)); // R11
endmodule

bind cfpred_mask_gen cfpred_checker #(.LANES(LANES), .VL_W(VL_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .step_mode (step_mode),
    .vec_len   (vec_len),
    .mask      (mask),
    .done      (done),
    .busy      (busy),
    .vl_err    (vl_err)
);

// File: tb/tb_cfpred_mask_gen.sv
module tb_cfpred_mask_gen;
    localparam int NF    = 64;
    localparam int BASE  = 48;
    localparam int VLW   = 7;
    localparam int LN    = NF - BASE;
    localparam int BW    = NF * 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          step_mode = 1'b0;
    logic [2:0]    cond_sel = '0;
    logic [VLW-1:0] vec_len = '0;
    logic [BW-1:0] cf_bank = '0;
    logic [LN-1:0] mask;
    logic          done, busy, vl_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk; // 50 MHz

    cfpred_mask_gen #(.NUM_FIELDS(NF), .BASE_FIELD(BASE), .VL_W(VLW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .step_mode(step_mode),
        .cond_sel(cond_sel), .vec_len(vec_len), .cf_bank(cf_bank),
        .mask(mask), .done(done), .busy(busy), .vl_err(vl_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected mask from the requirements: field BASE+i, flag bit 3-sel[2:1], polarity sel[0].
    function automatic logic [LN-1:0] exp_mask(input logic [BW-1:0] bank, input logic [2:0] sel, input int eff);
        logic [LN-1:0] m = '0;
        for (int i = 0; i < eff; i++) begin
            logic [3:0] nib = bank[4*(BASE+i) +: 4];
            m[i] = nib[3 - int'(sel[2:1])] ^ sel[0];
        end
        return m;
    endfunction

    task automatic run_one(input logic [BW-1:0] bank, input logic [2:0] sel, input int vl, input logic stepped);
        int eff = (vl > LN) ? LN : vl;
        logic [LN-1:0] em = exp_mask(bank, sel, eff);
        logic eerr = (vl > LN);
        int cycles = 0;
        bit injected = 0;
        @(negedge clk);
        cf_bank = bank; cond_sel = sel; vec_len = VLW'(vl); step_mode = stepped; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!stepped || eff == 0) begin
            chk(done == 1'b1, eff == 0 ? "R9 done" : "R6 done", 32'(done), 1);
            chk(busy == 1'b0, eff == 0 ? "R9 busy" : "R6 busy", 32'(busy), 0);
        end else begin
            while (!done && cycles < 40) begin
                chk(busy == 1'b1, "R7 busy", 32'(busy), 1);
                if (cycles == 1 && eff >= 3) begin
                    start = 1'b1; cond_sel = ~sel; vec_len = VLW'(5); step_mode = 1'b0;
                    injected = 1;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
                cycles++;
            end
            chk(cycles == eff, "R7 walk length", 32'(cycles), 32'(eff));
            chk(busy == 1'b0, "R7 busy at done", 32'(busy), 0);
            if (injected)
                chk(mask == em && vl_err == eerr, "R8 ignored start", 32'(mask), 32'(em));
        end
        chk(mask == em, "R3 R2 R1 mask", 32'(mask), 32'(em));
        chk((32'(mask) >> eff) == 0, "R4 upper bits", 32'(mask), 32'(em));
        chk(vl_err == eerr, "R5 vl_err", 32'(vl_err), 32'(eerr));
        @(negedge clk);
        chk(done == 1'b0, "R11 done pulse", 32'(done), 0);
        chk(mask == em, "R11 mask held", 32'(mask), 32'(em));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [BW-1:0] banks [4];
        logic [31:0] x = 32'h1234_5678;
        banks[0] = '0;
        banks[1] = '1;
        for (int b = 2; b < 4; b++)
            for (int w = 0; w < BW/32; w++) begin
                x ^= x << 13; x ^= x >> 17; x ^= x << 5;
                banks[b][w*32 +: 32] = x;
            end
        repeat (3) @(negedge clk);
        chk(mask == '0, "R10 mask", 32'(mask), 0);
        chk(done == 1'b0 && busy == 1'b0 && vl_err == 1'b0, "R10 flags",
            {29'd0, done, busy, vl_err}, 0);
        rst_n = 1'b1;
        for (int b = 0; b < 4; b++)
            for (int s = 0; s < 8; s++)
                for (int v = 0; v <= 18; v++)
                    for (int m = 0; m < 2; m++)
                        run_one(banks[b], 3'(s), v, 1'(m));
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule